// File: doc/BRIEF.md
# Serial Shift Register Peripheral with Interrupt Control

This block is a byte-wide, memory-mapped peripheral that a host reaches through a simple select/write bus with a 4-bit register index. Its core is an 8-bit shift register that moves data in step with an external serial clock. The shift register either collects bits from a serial input, or sends its contents out on a serial output. Alongside it sit an 8-bit general purpose port with a per-pin direction register, a control register whose mode field picks the shift behaviour, and a pair of interrupt registers.

When eight bits have moved, a completion flag rises. The host clears that flag by writing a one to it, or as a side effect of any read or write of the shift register. That same access also restarts the bit count. Interrupt enables are changed through a set/clear write, and a single interrupt output reports whether any enabled flag is pending.

The external serial clock is asynchronous to the bus clock. It passes through a two-stage synchroniser before its edges are detected. The serial clock must therefore stay at each level for at least three bus clock cycles.

Top module: `serial_shift_periph`

## Requirements
- R1: After reset the port latch, direction, shift and control registers read 0x00, the flag register reads 0x00, the enable register reads 0x80, `irq` is 0 and `serOut` is 1.
- R2: The register index decodes as 0 = port data, 2 = port direction, 10 = shift register, 11 = control, 13 = flags, 14 = enables; every other index reads 0x00 and ignores writes.
- R3: A direction bit of 1 drives that port pin from the output latch (`portBOut`, with `portBDir` mirroring the direction register). A read of index 0 returns the latch bit for output pins and the `portBIn` bit for input pins.
- R4: With control bits 4:2 = 3'b011, each rising edge of `serClk` shifts `serIn` into the shift register's LSB, moving older bits toward the MSB. Eight rising edges therefore leave the first bit received in bit 7. An edge takes effect within three clock cycles.
- R5: With control bits 4:2 = 3'b111, `serOut` shows shift register bit 7, and each falling edge of `serClk` rotates the register left by one. After eight falling edges, the bits 7..0 have appeared in that order and the register again holds its loaded value. In any other mode `serOut` is 1.
- R6: Flag bit 2 sets on the eighth shift after the last shift register access. Further serial clock edges then leave the shift register and flag unchanged until the next access.
- R7: A read or a write of the shift register clears flag bit 2 and restarts the count, so that a full eight further shifts are needed to set it again. A write also loads the written byte.
- R8: A write to the flag register clears flag bit 2 when written bit 2 is 1; written zeros and written bit 7 have no effect.
- R9: A write to the enable register with bit 7 = 1 sets every enable bit written as 1. With bit 7 = 0 it clears every enable bit written as 1. Enable bit 7 always reads 1.
- R10: Flag register bit 7 reads 1, and `irq` is 1, exactly when some flag and its enable bit are both 1.
- R11: With control bits 4:2 neither 3'b011 nor 3'b111, serial clock edges change neither the shift register nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register index |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the selected index (combinational) |
| serClk | input | 1 | External serial shift clock, asynchronous |
| serIn | input | 1 | Serial data input |
| serOut | output | 1 | Serial data output |
| portBIn | input | 8 | Levels on the port pins |
| portBOut | output | 8 | Port output latch |
| portBDir | output | 8 | Per-pin output enable (1 = output) |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bit counter and the synchronised serial clock cannot be seen directly. A counter that is off by one shows up at the ports as a completion flag that rises one serial edge early or late. It also leaves a shift register value off by one position, which the next read of index 10 exposes. A missed restart on access is caught when a partial transfer is followed by a write and the flag appears before eight further edges. Errors in the enable or flag logic appear at `irq` and flag bit 7 within one clock of the register write that causes them.

// File: rtl/sr_periph_pkg.sv
package sr_periph_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [3:0] IDX_PORT   = 4'd0;
  localparam logic [3:0] IDX_DIR    = 4'd2;
  localparam logic [3:0] IDX_SHIFT  = 4'd10;
  localparam logic [3:0] IDX_CTRL   = 4'd11;
  localparam logic [3:0] IDX_FLAG   = 4'd13;
  localparam logic [3:0] IDX_ENABLE = 4'd14;

  localparam int FLAG_DONE = 2;
  localparam int MODE_LSB  = 2;
  localparam logic [2:0] MODE_IN  = 3'b011;
  localparam logic [2:0] MODE_OUT = 3'b111;

  typedef struct packed {
    logic wrPort;
    logic wrDir;
    logic wrCtrl;
    logic wrFlag;
    logic wrEnable;
    logic loadShift;
    logic touchShift;
    logic stepIn;
    logic stepOut;
    logic setDone;
  } strobe_t;
endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import sr_periph_pkg::*;
#(
  parameter int DW = sr_periph_pkg::DATA_W,
  parameter int AW = sr_periph_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busSel,
  input  logic          busWr,
  input  logic [AW-1:0] busAddr,
  input  logic          serClk,
  input  logic [2:0]    modeSel,
  output strobe_t       stb
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

  logic [2:0]       syncQ;
  logic [CNT_W-1:0] bitCnt;
  logic             clkRise, clkFall, isWrite, touch, busy, modeIn, modeOut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[1:0], serClk};
  end

  assign clkRise = syncQ[1] & ~syncQ[2];
  assign clkFall = ~syncQ[1] & syncQ[2];
  assign isWrite = busSel & busWr;
  assign touch   = busSel && (busAddr == AW'(IDX_SHIFT));
  assign busy    = bitCnt < FULL;
  assign modeIn  = (modeSel == MODE_IN);
  assign modeOut = (modeSel == MODE_OUT);

  always_comb begin
    stb            = '0;
    stb.wrPort     = isWrite && (busAddr == AW'(IDX_PORT));
    stb.wrDir      = isWrite && (busAddr == AW'(IDX_DIR));
    stb.wrCtrl     = isWrite && (busAddr == AW'(IDX_CTRL));
    stb.wrFlag     = isWrite && (busAddr == AW'(IDX_FLAG));
    stb.wrEnable   = isWrite && (busAddr == AW'(IDX_ENABLE));
    stb.loadShift  = isWrite && touch;
    stb.touchShift = touch;
    stb.stepIn     = !touch && busy && modeIn && clkRise;
    stb.stepOut    = !touch && busy && modeOut && clkFall;
    stb.setDone    = (stb.stepIn || stb.stepOut) && (bitCnt == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       bitCnt <= '0;
    else if (touch)                   bitCnt <= '0;
    else if (stb.stepIn || stb.stepOut) bitCnt <= bitCnt + 1'b1;
  end

  // R6: the count never runs past one full byte
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= FULL);

  // R7: an access restarts the count
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> (bitCnt == '0));

  // R6: once a byte is complete no further shift strobes issue
  a_r6_no_extra_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bitCnt == FULL) |-> !(stb.stepIn || stb.stepOut));
endmodule

// File: rtl/sr_datapath.sv
module sr_datapath
  import sr_periph_pkg::*;
#(
  parameter int DW = sr_periph_pkg::DATA_W,
  parameter int AW = sr_periph_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       stb,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic [DW-1:0] portBIn,
  input  logic          serIn,
  output logic [DW-1:0] busRdata,
  output logic          serOut,
  output logic [DW-1:0] portBOut,
  output logic [DW-1:0] portBDir,
  output logic [2:0]    modeSel,
  output logic          irq
);
  logic [DW-1:0] portLatch, dirReg, shiftReg, ctrlReg;
  logic [DW-2:0] enReg, flagVec;
  logic          doneFlag, anyIrq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      portLatch <= '0;
      dirReg    <= '0;
      ctrlReg   <= '0;
      shiftReg  <= '0;
      doneFlag  <= 1'b0;
      enReg     <= '0;
    end else begin
      if (stb.wrPort) portLatch <= busWdata;
      if (stb.wrDir)  dirReg    <= busWdata;
      if (stb.wrCtrl) ctrlReg   <= busWdata;

      if (stb.loadShift)    shiftReg <= busWdata;
      else if (stb.stepIn)  shiftReg <= {shiftReg[DW-2:0], serIn};
      else if (stb.stepOut) shiftReg <= {shiftReg[DW-2:0], shiftReg[DW-1]};

      if (stb.setDone)                               doneFlag <= 1'b1;
      else if (stb.touchShift)                       doneFlag <= 1'b0;
      else if (stb.wrFlag && busWdata[FLAG_DONE])    doneFlag <= 1'b0;

      if (stb.wrEnable) begin
        if (busWdata[DW-1]) enReg <= enReg | busWdata[DW-2:0];
        else                enReg <= enReg & ~busWdata[DW-2:0];
      end
    end
  end

  always_comb begin
    flagVec            = '0;
    flagVec[FLAG_DONE] = doneFlag;
  end

  assign anyIrq   = |(flagVec & enReg);
  assign irq      = anyIrq;
  assign modeSel  = ctrlReg[MODE_LSB+2:MODE_LSB];
  assign serOut   = (modeSel == MODE_OUT) ? shiftReg[DW-1] : 1'b1;
  assign portBOut = portLatch;
  assign portBDir = dirReg;

  always_comb begin
    unique case (busAddr)
      AW'(IDX_PORT):   busRdata = (portLatch & dirReg) | (portBIn & ~dirReg);
      AW'(IDX_DIR):    busRdata = dirReg;
      AW'(IDX_SHIFT):  busRdata = shiftReg;
      AW'(IDX_CTRL):   busRdata = ctrlReg;
      AW'(IDX_FLAG):   busRdata = {anyIrq, flagVec};
      AW'(IDX_ENABLE): busRdata = {1'b1, enReg};
      default:         busRdata = '0;
    endcase
  end

  // R6: the flag only rises on the strobe for the eighth shift
  a_r6_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneFlag) |-> $past(stb.setDone));

  // R7: any shift register access leaves the flag clear
  a_r7_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stb.touchShift |=> !doneFlag);

  // R8: writing a one to flag bit 2 clears it
  a_r8_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrFlag && busWdata[FLAG_DONE] && !stb.setDone) |=> !doneFlag);

  // R9: a clear-type enable write leaves the written bits at zero
  a_r9_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrEnable && !busWdata[DW-1]) |=> ((enReg & $past(busWdata[DW-2:0])) == '0));

  // R11: without a shift strobe or load the shift register holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.loadShift || stb.stepIn || stb.stepOut) |=> $stable(shiftReg));
endmodule

// File: rtl/serial_shift_periph.sv
module serial_shift_periph
  import sr_periph_pkg::*;
#(
  parameter int DW = sr_periph_pkg::DATA_W,
  parameter int AW = sr_periph_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busSel,
  input  logic          busWr,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  input  logic          serClk,
  input  logic          serIn,
  output logic          serOut,
  input  logic [DW-1:0] portBIn,
  output logic [DW-1:0] portBOut,
  output logic [DW-1:0] portBDir,
  output logic          irq
);
  strobe_t    stb;
  logic [2:0] modeSel;

  sr_ctrl #(.DW(DW), .AW(AW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .serClk(serClk), .modeSel(modeSel), .stb(stb)
  );

  sr_datapath #(.DW(DW), .AW(AW)) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .busAddr(busAddr),
    .busWdata(busWdata), .portBIn(portBIn), .serIn(serIn),
    .busRdata(busRdata), .serOut(serOut), .portBOut(portBOut),
    .portBDir(portBDir), .modeSel(modeSel), .irq(irq)
  );
endmodule

// File: tb/test_serial_shift_periph.sv
`timescale 1ns/1ps
module test_serial_shift_periph;
  logic       clk = 0, rst_n = 0;
  logic       busSel = 0, busWr = 0;
  logic [3:0] busAddr = 0;
  logic [7:0] busWdata = 0, busRdata;
  logic       serClk = 0, serIn = 0, serOut;
  logic [7:0] portBIn = 0, portBOut, portBDir;
  logic       irq;
  int errors = 0, checks = 0;
  logic done = 0;

  // reference model state
  logic [7:0] mSr, mEn;
  logic       mFlag;
  int         mCnt;

  always #4 clk = ~clk;

  serial_shift_periph i_serial_shift_periph (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .serClk(serClk), .serIn(serIn), .serOut(serOut), .portBIn(portBIn),
    .portBOut(portBOut), .portBDir(portBDir), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic mIrq();
    return mFlag && mEn[2];
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
    if (a == 4'd10) begin mSr = d; mFlag = 0; mCnt = 0; end
    if (a == 4'd13 && d[2]) mFlag = 0;
    if (a == 4'd14) mEn = d[7] ? (mEn | {1'b0, d[6:0]}) : (mEn & ~{1'b0, d[6:0]});
  endtask

  task automatic rd(input logic [3:0] a, input int exp, input string tag);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1 check(tag, busRdata, exp);
    @(negedge clk);
    busSel = 0;
    if (a == 4'd10) begin mFlag = 0; mCnt = 0; end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // one rising edge of the serial clock in shift-in mode
  task automatic bitIn(input logic b, input logic active);
    serIn = b; serClk = 0; settle();
    serClk = 1; settle();
    if (active && mCnt < 8) begin
      mSr = {mSr[6:0], b}; mCnt++;
      if (mCnt == 8) mFlag = 1;
    end
  endtask

  task automatic bitOut();
    serClk = 1; settle();
    serClk = 0; settle();
    if (mCnt < 8) begin
      mSr = {mSr[6:0], mSr[7]}; mCnt++;
      if (mCnt == 8) mFlag = 1;
    end
  endtask

  task automatic checkFlags(input string tag);
    rd(4'd13, {mIrq(), 4'b0, mFlag, 2'b0}, tag);
    check({tag, " irq"}, irq, mIrq());
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
  end

  initial begin
    mSr = 0; mEn = 0; mFlag = 0; mCnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'd0, 8'h00, "R1 port");
    rd(4'd2, 8'h00, "R1 dir");
    rd(4'd10, 8'h00, "R1 shift");
    rd(4'd11, 8'h00, "R1 ctrl");
    rd(4'd13, 8'h00, "R1 flag");
    rd(4'd14, 8'h80, "R1 enable");
    check("R1 irq", irq, 0);
    check("R1 serOut", serOut, 1);

    // R3 port direction and readback
    wr(4'd2, 8'hF0); wr(4'd0, 8'hA5); portBIn = 8'h3C;
    check("R3 portBOut", portBOut, 8'hA5);
    check("R3 portBDir", portBDir, 8'hF0);
    rd(4'd0, 8'hAC, "R3 mixed read");

    // R2 unused index ignores writes
    wr(4'd5, 8'hFF);
    rd(4'd5, 8'h00, "R2 unused index");
    rd(4'd2, 8'hF0, "R2 dir unchanged");

    // R9 enable set/clear
    wr(4'd14, 8'h86); rd(4'd14, 8'h86, "R9 set");
    wr(4'd14, 8'h02); rd(4'd14, 8'h84, "R9 clear");
    wr(4'd14, 8'h04); rd(4'd14, 8'h80, "R9 clear all");

    // R4 shift in 0xA5
    wr(4'd11, 8'h0C); rd(4'd11, 8'h0C, "R4 ctrl readback");
    rd(4'd10, 8'h00, "R4 pre");
    for (int i = 7; i >= 0; i--) begin
      bitIn(8'hA5 >> i, 1);
      if (i == 1) checkFlags("R6 not yet after 7");
    end
    checkFlags("R6 flag after 8");
    // R10 enable the flag
    wr(4'd14, 8'h84); checkFlags("R10 irq on");
    // R6 ninth edge ignored
    bitIn(0, 1);
    // R8 write-one-to-clear semantics
    wr(4'd13, 8'h00); checkFlags("R8 zero write");
    wr(4'd13, 8'h80); checkFlags("R8 bit7 write");
    rd(4'd10, 8'hA5, "R4 R6 shifted byte");
    checkFlags("R7 read clears");
    check("R5 serOut idle in shift-in", serOut, 1);

    // R7 restart on write mid-transfer
    bitIn(1, 1); bitIn(1, 1); bitIn(0, 1);
    wr(4'd10, 8'h00);
    for (int i = 0; i < 5; i++) bitIn(i[0], 1);
    checkFlags("R7 restarted count");
    for (int i = 0; i < 3; i++) bitIn(1, 1);
    checkFlags("R7 full count after write");
    rd(4'd10, mSr, "R7 content");
    // R8 clear by write after new completion
    for (int i = 0; i < 8; i++) bitIn(i[1], 1);
    checkFlags("R8 set again");
    wr(4'd13, 8'h04); checkFlags("R8 one clears");

    // R5 shift out 0x3C
    wr(4'd11, 8'h1C); wr(4'd10, 8'h3C);
    check("R5 first bit", serOut, 0);
    for (int k = 1; k <= 8; k++) begin
      bitOut();
      check("R5 serOut bit", serOut, (k == 8) ? 0 : ((8'h3C >> (7 - k)) & 1));
    end
    checkFlags("R5 R6 flag after out");
    rd(4'd10, 8'h3C, "R5 rotated back");

    // R11 inactive mode
    wr(4'd11, 8'h00); wr(4'd10, 8'h5A);
    for (int i = 0; i < 8; i++) bitIn(1, 0);
    rd(4'd10, 8'h5A, "R11 shift unchanged");
    checkFlags("R11 no flag");
    check("R11 serOut", serOut, 1);

    done = 1;
  end

  initial begin
    wait (done);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule